// File: doc/BRIEF.md
# GPIO Channel with Per-Pin Interrupt Detection

This block is a single general-purpose I/O channel of up to sixteen pins. It is controlled through a bank of twelve 32-bit words on a simple register port. Software chooses the direction of each pin and sets the value that output pins drive. It reads the pin levels after a two-flop synchronizer. Each pin can raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level.

Pending events are kept in a status word. Software clears a status bit by writing a one to it, and writing zeros changes nothing. A mask can be set and cleared bit by bit through two separate write-one words. The unmasked pending bits are visible in a display word, and any one of them drives the single interrupt request. A soft-reset input returns every register of the channel to zero for as long as it is held high.

Top module: `gpio_chan`

## Requirements
- R1: After `rst`, or after a pulse on `soft_rst`, these all read zero: enable, status, mask, output, direction, both mode words, `irq`, `pin_out` and `pin_oe`. Zero mode means falling edge.
- R2: Direction bit p set to 1 drives `pin_oe[p]` high. Output bit p drives `pin_out[p]`. Direction and output bits at or above NPINS read as zero and ignore writes.
- R3: Word 7 returns the pin levels through a two-flop synchronizer. A change applied before clock edge k is visible in a read during the cycle after edge k+1.
- R4: Pin p keeps a 3-bit trigger code. For p<8 the code sits in word 9 at bit 4p. For p≥8 it sits in word 10 at bit 4(p−8). The fourth bit of every field reads zero, so writing all ones to a mode word reads back 0x77777777.
- R5: Code 0 sets the pin's status bit on a falling edge, code 1 on a rising edge, and code 4 on either edge. A steady level does not set it again after a clear.
- R6: Code 2 (low) and code 3 (high) set status while the level holds. After a clear, the bit reads zero for one cycle and is set again on the next cycle if the level is still active.
- R7: A status bit is never newly set while the pin's bit in word 0 (enable) is zero.
- R8: Writing a one to a bit of word 3 clears that status bit. Zero bits have no effect. A clear wins over a detection in the same cycle. Word 3 reads zero.
- R9: A one written to word 4 masks the pin, and a one written to word 5 unmasks it. Zero bits have no effect. Both words read back the mask. Word 2 reads status AND NOT mask, and `irq` is the OR of word 2.
- R10: Trigger codes 5, 6 and 7 never set status.
- R11: Word 11 always reads zero. Word 1 (status) is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous soft reset of all channel state |
| addr | input | 4 | Word index of the register access |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed word (combinational) |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output values |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the single cycle in which a level-triggered status bit reads zero. This happens right after a clear while the level is still active. The stimulus issues a read on the very cycle after the clear write, so this zero is observed, and a second read then shows the bit set again. The bench shows the synchronizer latency in the same way: it changes a pin and reads the input word on three consecutive cycles. Edge modes use a different sequence. A pin is first parked at the opposite level while its enable bit is off, and is only moved after the enable is written. This way each event comes from the configured edge alone and not from a stale transition.

// File: rtl/gpio_chan_pkg.sv
package gpio_chan_pkg;

    localparam int DW = 32;
    localparam int AW = 4;

    typedef enum logic [AW-1:0] {
        RG_ENABLE  = 4'd0,
        RG_STATUS  = 4'd1,
        RG_DISPLAY = 4'd2,
        RG_CLEAR   = 4'd3,
        RG_MSET    = 4'd4,
        RG_MCLR    = 4'd5,
        RG_OUT     = 4'd6,
        RG_IN      = 4'd7,
        RG_DIR     = 4'd8,
        RG_MODE0   = 4'd9,
        RG_MODE1   = 4'd10,
        RG_RSVD    = 4'd11
    } reg_idx_e;

    typedef enum logic [2:0] {
        TRG_FALL = 3'd0,
        TRG_RISE = 3'd1,
        TRG_LOW  = 3'd2,
        TRG_HIGH = 3'd3,
        TRG_BOTH = 3'd4
    } trig_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_obs_t;

    function automatic logic trig_hit(logic [2:0] mode, pin_obs_t o);
        logic h;
        case (mode)
            TRG_FALL: h = o.fall;
            TRG_RISE: h = o.rise;
            TRG_LOW:  h = ~o.lvl;
            TRG_HIGH: h = o.lvl;
            TRG_BOTH: h = o.rise | o.fall;
            default:  h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/gpio_chan_sync.sv
module gpio_chan_sync
    import gpio_chan_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPINS-1:0]           pin_in,
    output logic [NPINS-1:0]           level,
    output pin_obs_t [NPINS-1:0]       obs
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic s1_q, s2_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin_in[p];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end
        assign level[p]    = s2_q;
        assign obs[p].lvl  = s2_q;
        assign obs[p].rise = s2_q & ~prev_q;
        assign obs[p].fall = ~s2_q & prev_q;
    end

endmodule

// File: rtl/gpio_chan_trig.sv
module gpio_chan_trig
    import gpio_chan_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic [NPINS-1:0][2:0]      mode,
    input  pin_obs_t [NPINS-1:0]       obs,
    output logic [NPINS-1:0]           hit
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign hit[p] = trig_hit(mode[p], obs[p]);
    end

endmodule

// File: rtl/gpio_chan_irq.sv
module gpio_chan_irq #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] en,
    input  logic             clr_we,
    input  logic             mset_we,
    input  logic             mclr_we,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] sts,
    output logic [NPINS-1:0] msk,
    output logic [NPINS-1:0] disp,
    output logic             irq
);

    logic [NPINS-1:0] clr_bits;
    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
        end else begin
            sts <= (sts | (hit & en)) & ~clr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msk <= '0;
        end else if (mset_we) begin
            msk <= msk | wdata;
        end else if (mclr_we) begin
            msk <= msk & ~wdata;
        end
    end

    assign disp = sts & ~msk;
    assign irq  = |disp;

endmodule

// File: rtl/gpio_chan.sv
module gpio_chan
    import gpio_chan_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic [3:0]       addr,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);

    localparam int FIELD = 4;
    localparam int LOW_PINS = 8;

    logic rst_all;
    assign rst_all = rst | soft_rst;

    logic [NPINS-1:0]      en_q, out_q, dir_q;
    logic [NPINS-1:0][2:0] mode_vec;
    logic [NPINS-1:0]      level, hit, sts_vec, msk_vec, disp_vec;
    pin_obs_t [NPINS-1:0]  obs;
    logic [NPINS-1:0]      wd;
    logic                  unused_wbits;

    assign wd           = wr_data[NPINS-1:0];
    assign unused_wbits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            en_q  <= '0;
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            if (addr == RG_ENABLE) en_q  <= wd;
            if (addr == RG_OUT)    out_q <= wd;
            if (addr == RG_DIR)    dir_q <= wd;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_mode
        localparam logic [3:0] WORD = (p < LOW_PINS) ? RG_MODE0 : RG_MODE1;
        localparam int LSB = (p < LOW_PINS) ? FIELD * p : FIELD * (p - LOW_PINS);
        logic [2:0] m_q;
        always_ff @(posedge clk) begin
            if (rst_all) begin
                m_q <= '0;
            end else if (wr_en && addr == WORD) begin
                m_q <= wr_data[LSB +: 3];
            end
        end
        assign mode_vec[p] = m_q;
    end

    gpio_chan_sync #(.NPINS(NPINS)) sync_i (
        .clk    (clk),
        .rst    (rst_all),
        .pin_in (pin_in),
        .level  (level),
        .obs    (obs)
    );

    gpio_chan_trig #(.NPINS(NPINS)) trig_i (
        .mode (mode_vec),
        .obs  (obs),
        .hit  (hit)
    );

    gpio_chan_irq #(.NPINS(NPINS)) irq_i (
        .clk     (clk),
        .rst     (rst_all),
        .hit     (hit),
        .en      (en_q),
        .clr_we  (wr_en && addr == RG_CLEAR),
        .mset_we (wr_en && addr == RG_MSET),
        .mclr_we (wr_en && addr == RG_MCLR),
        .wdata   (wd),
        .sts     (sts_vec),
        .msk     (msk_vec),
        .disp    (disp_vec),
        .irq     (irq)
    );

    function automatic logic [DW-1:0] zx(logic [NPINS-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    logic [DW-1:0] mode_w0, mode_w1;
    always_comb begin
        mode_w0 = '0;
        mode_w1 = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (p < LOW_PINS) mode_w0[FIELD*p +: 3] = mode_vec[p];
            else              mode_w1[FIELD*(p-LOW_PINS) +: 3] = mode_vec[p];
        end
    end

    always_comb begin
        case (addr)
            RG_ENABLE:  rd_data = zx(en_q);
            RG_STATUS:  rd_data = zx(sts_vec);
            RG_DISPLAY: rd_data = zx(disp_vec);
            RG_MSET:    rd_data = zx(msk_vec);
            RG_MCLR:    rd_data = zx(msk_vec);
            RG_OUT:     rd_data = zx(out_q);
            RG_IN:      rd_data = zx(level);
            RG_DIR:     rd_data = zx(dir_q);
            RG_MODE0:   rd_data = mode_w0;
            RG_MODE1:   rd_data = mode_w1;
            default:    rd_data = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_chan_chk.sv
module gpio_chan_chk
    import gpio_chan_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic [3:0]       addr,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] sts,
    input logic [NPINS-1:0] msk,
    input logic [NPINS-1:0] en
);

    // R1: soft reset empties status and releases all pins
    a_r1_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (sts == '0 && pin_oe == '0 && !irq));

    // R2: a direction write appears on the output enables
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RG_DIR && !soft_rst) |=> pin_oe == $past(wr_data[NPINS-1:0]));

    // R7: no status bit rises for a pin whose enable was off
    a_r7_enable_gates: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts & ~$past(sts) & ~$past(en)) == '0));

    // R8: every bit written as one to the clear word is zero afterwards
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RG_CLEAR) |=> ((sts & $past(wr_data[NPINS-1:0])) == '0));

    // R9: a fully masked channel never requests
    a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (&msk) |-> !irq);

endmodule

bind gpio_chan gpio_chan_chk #(.NPINS(NPINS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .sts      (sts_vec),
    .msk      (msk_vec),
    .en       (en_q)
);

// File: tb/gpio_chan_tb_top.sv
`timescale 1ns/1ps
module gpio_chan_tb_top;

    localparam int NP = 16;
    localparam logic [3:0] A_EN = 0, A_STS = 1, A_DISP = 2, A_CLR = 3, A_MSET = 4,
                           A_MCLR = 5, A_OUT = 6, A_IN = 7, A_DIR = 8, A_M0 = 9,
                           A_M1 = 10, A_RSVD = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          soft_rst = 1'b0;
    logic [3:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    always #4 clk = ~clk;

    gpio_chan #(.NPINS(NP)) dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    total = 0;
    int    bad = 0;
    logic  chk_pend = 1'b0;
    logic  done = 1'b0;

    always @(negedge clk) begin
        if (chk_pend && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = rd_data;
                1:       act = {31'd0, irq};
                default: act = {pin_oe, pin_out};
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic push_chk(int kind, logic [3:0] a, logic [31:0] e, string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        addr = a; chk_pend = 1'b1;
        tick(1);
        chk_pend = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] e, string tag);
        push_chk(0, a, e, tag);
    endtask

    task automatic chk_irq(logic e, string tag);
        push_chk(1, addr, {31'd0, e}, tag);
    endtask

    task automatic chk_pins(logic [31:0] e, string tag);
        push_chk(2, addr, e, tag);
    endtask

    task automatic set_pin(logic [NP-1:0] v);
        pin_in = v;
        tick(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        rd(A_EN, 0, "R1 enable reset");
        rd(A_STS, 0, "R1 status reset");
        rd(A_DIR, 0, "R1 direction reset");
        rd(A_M0, 0, "R1 mode0 reset");
        rd(A_M1, 0, "R1 mode1 reset");
        chk_irq(1'b0, "R1 irq reset");
        chk_pins(0, "R1 pins reset");
        // R2 direction and output
        wr(A_DIR, 32'hFFFF_FFFF);
        rd(A_DIR, 32'h0000_FFFF, "R2 upper direction bits zero");
        wr(A_OUT, 32'h0000_1234);
        chk_pins(32'hFFFF_1234, "R2 pins driven");
        wr(A_DIR, 32'h0000_00F0);
        chk_pins(32'h00F0_1234, "R2 partial direction");
        // R3 synchronized input
        set_pin(16'hA5A5);
        rd(A_IN, 32'h0000_A5A5, "R3 input pattern a");
        set_pin(16'h0000);
        rd(A_IN, 0, "R3 input pattern b");
        pin_in = 16'h0001;
        rd(A_IN, 0, "R3 latency first cycle");
        rd(A_IN, 0, "R3 latency second cycle");
        rd(A_IN, 1, "R3 latency third cycle");
        set_pin(16'h0000);
        // R4 mode layout
        wr(A_M0, 32'hFFFF_FFFF);
        rd(A_M0, 32'h7777_7777, "R4 mode0 fourth bits zero");
        wr(A_M1, 32'hFFFF_FFFF);
        rd(A_M1, 32'h7777_7777, "R4 mode1 fourth bits zero");
        wr(A_M0, 0);
        wr(A_M1, 0);
        // R5 rising edge on pin 3
        wr(A_M0, 32'h0000_1000);
        rd(A_M0, 32'h0000_1000, "R4 pin3 field");
        wr(A_EN, 32'h0000_0008);
        set_pin(16'h0008);
        rd(A_STS, 32'h8, "R5 rising edge");
        chk_irq(1'b1, "R9 irq on pending");
        wr(A_CLR, 0);
        rd(A_STS, 32'h8, "R8 zero clear no effect");
        wr(A_CLR, 32'h8);
        rd(A_STS, 0, "R5 edge no retrigger after clear");
        chk_irq(1'b0, "R9 irq idle");
        // R5 falling edge on pin 9
        set_pin(16'h0208);
        wr(A_EN, 32'h0000_0208);
        set_pin(16'h0008);
        rd(A_STS, 32'h200, "R5 falling edge pin9");
        wr(A_CLR, 32'h200);
        // R5 both edges on pin 5
        wr(A_M0, 32'h0040_1000);
        wr(A_EN, 32'h0000_0228);
        set_pin(16'h0028);
        rd(A_STS, 32'h20, "R5 both edges rise");
        wr(A_CLR, 32'h20);
        set_pin(16'h0008);
        rd(A_STS, 32'h20, "R5 both edges fall");
        wr(A_CLR, 32'h20);
        rd(A_STS, 0, "R8 cleared both");
        // R6 high level on pin 12
        wr(A_M1, 32'h0003_0000);
        wr(A_EN, 32'h0000_1228);
        rd(A_STS, 0, "R6 high level inactive");
        set_pin(16'h1008);
        rd(A_STS, 32'h1000, "R6 high level");
        wr(A_CLR, 32'h1000);
        rd(A_STS, 0, "R8 clear wins one cycle");
        rd(A_STS, 32'h1000, "R6 level sets again");
        set_pin(16'h0008);
        wr(A_CLR, 32'h1000);
        rd(A_STS, 0, "R6 released level");
        rd(A_STS, 0, "R6 stays clear");
        // R6 low level on pin 14
        wr(A_M1, 32'h0203_0000);
        wr(A_EN, 32'h0000_5228);
        tick(1);
        rd(A_STS, 32'h4000, "R6 low level");
        set_pin(16'h4008);
        wr(A_CLR, 32'h4000);
        rd(A_STS, 0, "R6 low released");
        // R7 disabled pin 2 (falling mode, enable off)
        set_pin(16'h400C);
        set_pin(16'h4008);
        rd(A_STS, 0, "R7 disabled pin ignored");
        // R9 mask
        set_pin(16'h0008);
        rd(A_STS, 32'h4000, "R6 low level again");
        chk_irq(1'b1, "R9 irq unmasked");
        wr(A_MSET, 32'h4000);
        chk_irq(1'b0, "R9 irq masked");
        rd(A_DISP, 0, "R9 display masked");
        rd(A_MSET, 32'h4000, "R9 mask readback");
        rd(A_STS, 32'h4000, "R9 status kept under mask");
        wr(A_MCLR, 0);
        chk_irq(1'b0, "R9 zero unmask no effect");
        wr(A_MCLR, 32'h4000);
        chk_irq(1'b1, "R9 irq after unmask");
        rd(A_DISP, 32'h4000, "R9 display unmasked");
        // R10 unused code on pin 0
        wr(A_M0, 32'h0040_1005);
        wr(A_EN, 32'h0000_5229);
        set_pin(16'h0009);
        set_pin(16'h0008);
        rd(A_STS, 32'h4000, "R10 unused code ignored");
        // R11 reserved and write-only words
        wr(A_RSVD, 32'hFFFF_FFFF);
        rd(A_RSVD, 0, "R11 reserved word");
        rd(A_CLR, 0, "R8 clear word reads zero");
        wr(A_STS, 32'h0000_0000);
        rd(A_STS, 32'h4000, "R11 status read-only");
        // R1 soft reset
        soft_rst = 1'b1;
        tick(1);
        soft_rst = 1'b0;
        rd(A_EN, 0, "R1 soft enable");
        rd(A_STS, 0, "R1 soft status");
        rd(A_MSET, 0, "R1 soft mask");
        rd(A_M0, 0, "R1 soft mode0");
        rd(A_M1, 0, "R1 soft mode1");
        rd(A_OUT, 0, "R1 soft output");
        chk_irq(1'b0, "R1 soft irq");
        chk_pins(0, "R1 soft pins");
        rd(A_IN, 32'h0008, "R3 input after soft reset");
        tick(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule